// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers event strobes from a network interface datapath into two status registers and drives one level-sensitive interrupt line. The first-level (main) register holds 32 bits. Receive and transmit events land at fixed bit positions in it. The second-level (management) register holds 16 bits of link and management events. Each register has its own mask, where a 1 suppresses the matching status bit.

The management level is folded into the main level through one summary bit, bit 23. When any unmasked management bit is set, bit 23 of the main status reads as 1 and the interrupt is raised. The main mask has no direct effect on bit 23. Reading a status register clears it, and an event that arrives in the same cycle as the clearing read is kept.

Software reaches the registers through a plain 32-bit word port. Read data is combinational while the read enable is high. A clearing read or a write takes effect at the next rising clock edge. A read and a write are never issued in the same cycle.

Top module: `nic_irq_collector`

## Requirements
- R1: After reset both status registers are 0, the main mask is 0xFF7FFFFF, the management mask is 0xFFFF, and irqOut is 0.
- R2: A high event strobe at a rising edge sets its main status bit from that edge on. The bit positions are evtRxToHost at 16, evtNoRxDesc at 17, evtTxDescDone at 24 and evtTxAllDone at 25. Each bit of evtMgmt sets the same bit of the management status.
- R3: irqOut is 1 exactly when some main status bit other than 23 is set with its mask bit at 0, or when some management status bit is set with its mask bit at 0.
- R4: A main status read shows bit 23 as 1 whenever the masked management status is nonzero, whatever the value of main mask bit 23. In that case irqOut is 1.
- R5: A read of the main status at offset 0x100 returns its value. At the next edge it clears every stored bit except bit 23.
- R6: A read of the management status at offset 0x204 returns its value. At the next edge it clears the whole register.
- R7: An event strobe in the same cycle as a clearing read or a write of its status register is kept in the status after that edge.
- R8: Offset 0x108 behaves as the main status and offset 0x10C behaves as the main mask, for both reads and writes.
- R9: Offset 0x000 always reads 0. Writing it with bit 0 set gives a one-cycle pulse on txRstPulse, and writing it with bit 1 set gives a one-cycle pulse on rxRstPulse, in the cycle after the write.
- R10: Reads from any offset other than 0x000, 0x100, 0x104, 0x108, 0x10C, 0x200 and 0x204 return 0, and writes to them change no register.
- R11: A write to the main mask (0x104), the management mask (0x200) or either status register replaces its stored value. The management registers take the low 16 bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W (12) | Byte offset of the access |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Read data; 0 when no read is active |
| evtRxToHost | input | 1 | Frame delivered to host |
| evtNoRxDesc | input | 1 | No receive descriptor available |
| evtTxDescDone | input | 1 | Transmit descriptor consumed |
| evtTxAllDone | input | 1 | Transmit queue drained |
| evtMgmt | input | MGMT_W (16) | Management event strobes |
| irqOut | output | 1 | Level interrupt |
| txRstPulse | output | 1 | Transmit reset request pulse |
| rxRstPulse | output | 1 | Receive reset request pulse |

## Verification
The stimulus is a seeded random mix of reads, writes, sparse event strobes and mask values across every defined offset, both aliases and several undefined offsets. With this mix the interrupt level is compared under masks that hide some set bits and leave others visible. Directed cases separate the summary bit from main mask bit 23 and show that stored bit 23 survives a clearing read. They also place an event in the same cycle as the read that clears its register, so that an event-wins ordering can be told apart from a clear-wins ordering. Reset defaults, reset-register pulses and writes to undefined offsets followed by readback of every register cover the remaining requirements.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int SUM_BIT = 23;
  localparam int EVT_N = 4;
  localparam int EVT_POS [EVT_N] = '{16, 17, 24, 25};

  localparam int OFF_RESET     = 'h000;
  localparam int OFF_MAIN_STAT = 'h100;
  localparam int OFF_MAIN_MASK = 'h104;
  localparam int OFF_ALIAS_ST  = 'h108;
  localparam int OFF_ALIAS_MK  = 'h10C;
  localparam int OFF_MGMT_MASK = 'h200;
  localparam int OFF_MGMT_STAT = 'h204;

  typedef struct packed {
    logic wrMainStat;
    logic wrMainMask;
    logic wrMgmtStat;
    logic wrMgmtMask;
    logic clrMainStat;
    logic clrMgmtStat;
    logic pulseTx;
    logic pulseRx;
  } regStrobes_t;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_MAIN_STAT,
    SEL_MAIN_MASK,
    SEL_MGMT_STAT,
    SEL_MGMT_MASK
  } rdSel_t;
endpackage

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        rstBits,
  output regStrobes_t       strobes,
  output rdSel_t            rdSel
);
  logic hitReset, hitMainStat, hitMainMask, hitMgmtStat, hitMgmtMask;

  always_comb begin
    hitReset    = (regAddr == ADDR_W'(OFF_RESET));
    hitMainStat = (regAddr == ADDR_W'(OFF_MAIN_STAT)) || (regAddr == ADDR_W'(OFF_ALIAS_ST));
    hitMainMask = (regAddr == ADDR_W'(OFF_MAIN_MASK)) || (regAddr == ADDR_W'(OFF_ALIAS_MK));
    hitMgmtStat = (regAddr == ADDR_W'(OFF_MGMT_STAT));
    hitMgmtMask = (regAddr == ADDR_W'(OFF_MGMT_MASK));
  end

  always_comb begin
    strobes             = '0;
    strobes.wrMainStat  = regWrEn && hitMainStat;
    strobes.wrMainMask  = regWrEn && hitMainMask;
    strobes.wrMgmtStat  = regWrEn && hitMgmtStat;
    strobes.wrMgmtMask  = regWrEn && hitMgmtMask;
    strobes.clrMainStat = regRdEn && !regWrEn && hitMainStat;
    strobes.clrMgmtStat = regRdEn && !regWrEn && hitMgmtStat;
    strobes.pulseTx     = regWrEn && hitReset && rstBits[0];
    strobes.pulseRx     = regWrEn && hitReset && rstBits[1];
  end

  always_comb begin
    rdSel = SEL_ZERO;
    if (regRdEn && !regWrEn) begin
      if (hitMainStat)      rdSel = SEL_MAIN_STAT;
      else if (hitMainMask) rdSel = SEL_MAIN_MASK;
      else if (hitMgmtStat) rdSel = SEL_MGMT_STAT;
      else if (hitMgmtMask) rdSel = SEL_MGMT_MASK;
    end
  end
endmodule

// File: rtl/nic_irq_dp.sv
module nic_irq_dp
  import nic_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MGMT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobes_t       strobes,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [EVT_N-1:0]  evtIn,
  input  logic [MGMT_W-1:0] evtMgmt,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              txRstPulse,
  output logic              rxRstPulse,
  output logic [DATA_W-1:0] mainStatQ,
  output logic [DATA_W-1:0] mainMaskQ,
  output logic [MGMT_W-1:0] mgmtStatQ,
  output logic [MGMT_W-1:0] mgmtMaskQ
);
  localparam logic [DATA_W-1:0] SUM_ONLY      = DATA_W'(1) << SUM_BIT;
  localparam logic [DATA_W-1:0] MAIN_MASK_RST = ~SUM_ONLY;

  logic [DATA_W-1:0] mainStat, mainMask, evtMain, mainNext, mainView;
  logic [MGMT_W-1:0] mgmtStat, mgmtMask, mgmtNext;
  logic [DATA_W-1:0] evtPart [EVT_N];
  logic              mgmtAny, mainAny;

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    assign evtPart[i] = evtIn[i] ? (DATA_W'(1) << EVT_POS[i]) : '0;
  end

  always_comb begin
    evtMain = '0;
    for (int i = 0; i < EVT_N; i++) evtMain = evtMain | evtPart[i];
  end

  always_comb begin
    if (strobes.wrMainStat)       mainNext = regWrData;
    else if (strobes.clrMainStat) mainNext = mainStat & SUM_ONLY;
    else                          mainNext = mainStat;
    mainNext = mainNext | evtMain;

    if (strobes.wrMgmtStat)       mgmtNext = regWrData[MGMT_W-1:0];
    else if (strobes.clrMgmtStat) mgmtNext = '0;
    else                          mgmtNext = mgmtStat;
    mgmtNext = mgmtNext | evtMgmt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mainStat   <= '0;
      mainMask   <= MAIN_MASK_RST;
      mgmtStat   <= '0;
      mgmtMask   <= '1;
      txRstPulse <= 1'b0;
      rxRstPulse <= 1'b0;
    end else begin
      mainStat   <= mainNext;
      mgmtStat   <= mgmtNext;
      if (strobes.wrMainMask) mainMask <= regWrData;
      if (strobes.wrMgmtMask) mgmtMask <= regWrData[MGMT_W-1:0];
      txRstPulse <= strobes.pulseTx;
      rxRstPulse <= strobes.pulseRx;
    end
  end

  always_comb begin
    mgmtAny  = |(mgmtStat & ~mgmtMask);
    mainAny  = |(mainStat & ~mainMask & ~SUM_ONLY);
    irqOut   = mainAny || mgmtAny;
    mainView = mainStat | (mgmtAny ? SUM_ONLY : '0);
  end

  always_comb begin
    unique case (rdSel)
      SEL_MAIN_STAT: regRdData = mainView;
      SEL_MAIN_MASK: regRdData = mainMask;
      SEL_MGMT_STAT: regRdData = DATA_W'(mgmtStat);
      SEL_MGMT_MASK: regRdData = DATA_W'(mgmtMask);
      default:       regRdData = '0;
    endcase
  end

  assign mainStatQ = mainStat;
  assign mainMaskQ = mainMask;
  assign mgmtStatQ = mgmtStat;
  assign mgmtMaskQ = mgmtMask;
endmodule

// File: rtl/nic_irq_collector.sv
module nic_irq_collector
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int MGMT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtRxToHost,
  input  logic              evtNoRxDesc,
  input  logic              evtTxDescDone,
  input  logic              evtTxAllDone,
  input  logic [MGMT_W-1:0] evtMgmt,
  output logic              irqOut,
  output logic              txRstPulse,
  output logic              rxRstPulse
);
  regStrobes_t       strobes;
  rdSel_t            rdSel;
  logic [DATA_W-1:0] mainStatQ, mainMaskQ;
  logic [MGMT_W-1:0] mgmtStatQ, mgmtMaskQ;
  logic [EVT_N-1:0]  evtIn;

  assign evtIn = {evtTxAllDone, evtTxDescDone, evtNoRxDesc, evtRxToHost};

  nic_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .rstBits (regWrData[1:0]),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  nic_irq_dp #(.DATA_W(DATA_W), .MGMT_W(MGMT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .regWrData  (regWrData),
    .evtIn      (evtIn),
    .evtMgmt    (evtMgmt),
    .regRdData  (regRdData),
    .irqOut     (irqOut),
    .txRstPulse (txRstPulse),
    .rxRstPulse (rxRstPulse),
    .mainStatQ  (mainStatQ),
    .mainMaskQ  (mainMaskQ),
    .mgmtStatQ  (mgmtStatQ),
    .mgmtMaskQ  (mgmtMaskQ)
  );
endmodule

// File: rtl/nic_irq_checker.sv
module nic_irq_checker
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int MGMT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              evtRxToHost,
  input logic [MGMT_W-1:0] evtMgmt,
  input logic              irqOut,
  input logic              txRstPulse,
  input logic [DATA_W-1:0] mainStatQ,
  input logic [DATA_W-1:0] mainMaskQ,
  input logic [MGMT_W-1:0] mgmtStatQ,
  input logic [MGMT_W-1:0] mgmtMaskQ
);
  logic undefAddr;
  assign undefAddr = !(regAddr == ADDR_W'(OFF_RESET) || regAddr == ADDR_W'(OFF_MAIN_STAT) ||
                       regAddr == ADDR_W'(OFF_MAIN_MASK) || regAddr == ADDR_W'(OFF_ALIAS_ST) ||
                       regAddr == ADDR_W'(OFF_ALIAS_MK) || regAddr == ADDR_W'(OFF_MGMT_MASK) ||
                       regAddr == ADDR_W'(OFF_MGMT_STAT));

  a_r2_rx_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evtRxToHost |=> mainStatQ[16]);

  a_r4_summary_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mgmtStatQ & ~mgmtMaskQ)) |-> irqOut);

  a_r5_read_keeps_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && !regWrEn && regAddr == ADDR_W'(OFF_MAIN_STAT))
      |=> mainStatQ[SUM_BIT] == $past(mainStatQ[SUM_BIT]));

  a_r6_mgmt_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && !regWrEn && regAddr == ADDR_W'(OFF_MGMT_STAT) && evtMgmt == '0)
      |=> mgmtStatQ == '0);

  a_r9_tx_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txRstPulse) |-> $past(regWrEn && regAddr == ADDR_W'(OFF_RESET) && regWrData[0]));

  a_r10_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && undefAddr) |-> regRdData == '0);

  a_r11_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == ADDR_W'(OFF_MAIN_MASK)) |=> mainMaskQ == $past(regWrData));
endmodule

bind nic_irq_collector nic_irq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MGMT_W(MGMT_W)) u_chk (.*);

// File: tb/sim_nic_irq_collector.sv
module sim_nic_irq_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evtRxToHost = 1'b0, evtNoRxDesc = 1'b0, evtTxDescDone = 1'b0, evtTxAllDone = 1'b0;
  logic [15:0] evtMgmt = '0;
  logic        irqOut, txRstPulse, rxRstPulse;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [31:0] mMain, mMainMask;
  logic [15:0] mMgmt, mMgmtMask;
  logic        expTx, expRx;

  always #10 clk = ~clk;

  nic_irq_collector u0 (.*);

  function automatic logic mgmtAnyExp();
    return |(mMgmt & ~mMgmtMask);
  endfunction

  function automatic logic irqExp();
    return (|(mMain & ~mMainMask & ~32'h0080_0000)) || mgmtAnyExp();
  endfunction

  function automatic logic [31:0] rdExp(logic [11:0] a);
    case (a)
      12'h100, 12'h108: return mMain | (mgmtAnyExp() ? 32'h0080_0000 : 32'h0);
      12'h104, 12'h10C: return mMainMask;
      12'h204: return {16'h0, mMgmt};
      12'h200: return {16'h0, mMgmtMask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(logic [11:0] a);
    case (a)
      12'h100: return "R5";
      12'h108, 12'h10C: return "R8";
      12'h104, 12'h200: return "R11";
      12'h204: return "R6";
      12'h000: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(bit wr, bit rd, logic [11:0] a, logic [31:0] d,
                      logic [3:0] ev, logic [15:0] me, string tag);
    logic [31:0] evMain;
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d;
    evtRxToHost = ev[0]; evtNoRxDesc = ev[1]; evtTxDescDone = ev[2]; evtTxAllDone = ev[3];
    evtMgmt = me;
    #1;
    if (rd) check(regRdData, rdExp(a), (tag != "") ? tag : tagFor(a));
    check({31'h0, irqOut}, {31'h0, irqExp()}, "R3");
    check({30'h0, txRstPulse, rxRstPulse}, {30'h0, expTx, expRx}, "R9");
    @(posedge clk);
    expTx = 1'b0; expRx = 1'b0;
    if (wr) begin
      case (a)
        12'h100, 12'h108: mMain = d;
        12'h104, 12'h10C: mMainMask = d;
        12'h204: mMgmt = d[15:0];
        12'h200: mMgmtMask = d[15:0];
        12'h000: begin expTx = d[0]; expRx = d[1]; end
        default: ;
      endcase
    end else if (rd) begin
      if (a == 12'h100 || a == 12'h108) mMain = mMain & 32'h0080_0000;
      if (a == 12'h204) mMgmt = '0;
    end
    evMain = '0;
    evMain[16] = ev[0]; evMain[17] = ev[1]; evMain[24] = ev[2]; evMain[25] = ev[3];
    mMain = mMain | evMain;
    mMgmt = mMgmt | me;
  endtask

  function automatic logic [11:0] pickAddr(int unsigned r);
    case (r % 10)
      0: return 12'h000;
      1: return 12'h100;
      2: return 12'h104;
      3: return 12'h108;
      4: return 12'h10C;
      5: return 12'h200;
      6: return 12'h204;
      7: return 12'h110;
      8: return 12'h102;
      default: return 12'h300;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd1234);
    mMain = '0; mMainMask = 32'hFF7F_FFFF; mMgmt = '0; mMgmtMask = 16'hFFFF;
    expTx = 1'b0; expRx = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset defaults
    doOp(0, 1, 12'h104, 0, 0, 0, "R1");
    doOp(0, 1, 12'h200, 0, 0, 0, "R1");
    doOp(0, 1, 12'h100, 0, 0, 0, "R1");
    doOp(0, 1, 12'h204, 0, 0, 0, "R1");
    check({31'h0, irqOut}, 32'h0, "R1");

    // R2: events land at their positions; masked by default so no irq
    doOp(0, 0, 12'h000, 0, 4'b1111, 16'h0000, "R2");
    doOp(0, 1, 12'h204, 0, 0, 0, "R2");
    doOp(0, 1, 12'h100, 0, 0, 0, "R2");
    doOp(0, 1, 12'h100, 0, 0, 0, "R2");

    // R4: summary bit independent of main mask bit 23
    doOp(1, 0, 12'h104, 32'hFFFF_FFFF, 0, 0, "R4");
    doOp(1, 0, 12'h200, 32'h0000_FFFE, 0, 0, "R4");
    doOp(0, 0, 12'h000, 0, 0, 16'h0001, "R4");
    doOp(0, 1, 12'h100, 0, 0, 0, "R4");
    check({31'h0, irqOut}, 32'h1, "R4");
    doOp(0, 1, 12'h204, 0, 0, 0, "R6");
    doOp(0, 1, 12'h100, 0, 0, 0, "R4");

    // R5: stored bit 23 survives a clearing read
    doOp(1, 0, 12'h100, 32'h0381_0000, 0, 0, "R5");
    doOp(0, 1, 12'h100, 0, 0, 0, "R5");
    doOp(0, 1, 12'h100, 0, 0, 0, "R5");

    // R7: event coinciding with clearing reads and writes
    doOp(0, 1, 12'h100, 0, 4'b0001, 0, "R7");
    doOp(0, 1, 12'h100, 0, 0, 0, "R7");
    doOp(0, 1, 12'h204, 0, 0, 16'h8000, "R7");
    doOp(0, 1, 12'h204, 0, 0, 0, "R7");
    doOp(1, 0, 12'h100, 32'h0, 4'b1000, 0, "R7");
    doOp(0, 1, 12'h100, 0, 0, 0, "R7");

    // R9: reset register pulses and reads zero
    doOp(1, 0, 12'h000, 32'h3, 0, 0, "R9");
    doOp(0, 1, 12'h000, 0, 0, 0, "R9");
    doOp(0, 0, 12'h000, 0, 0, 0, "R9");

    // R10: undefined writes change nothing
    doOp(1, 0, 12'h110, 32'hFFFF_FFFF, 0, 0, "R10");
    doOp(1, 0, 12'h106, 32'h0, 0, 0, "R10");
    doOp(0, 1, 12'h104, 0, 0, 0, "R10");
    doOp(0, 1, 12'h200, 0, 0, 0, "R10");
    doOp(0, 1, 12'h100, 0, 0, 0, "R10");
    doOp(0, 1, 12'h110, 0, 0, 0, "R10");

    // R8: aliases
    doOp(1, 0, 12'h10C, 32'h1234_5678, 0, 0, "R8");
    doOp(0, 1, 12'h104, 0, 0, 0, "R8");
    doOp(1, 0, 12'h108, 32'h0002_0000, 0, 0, "R8");
    doOp(0, 1, 12'h108, 0, 0, 0, "R8");

    // random mix
    for (int i = 0; i < 800; i++) begin
      int unsigned kind, ra;
      logic [31:0] d;
      logic [3:0] ev;
      logic [15:0] me;
      kind = $urandom % 4;
      ra = $urandom;
      d = $urandom;
      if ($urandom % 2 == 0) d = d | 32'hFF00_FF00;
      ev = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      me = (($urandom % 5) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      case (kind)
        0: doOp(0, 0, 12'h000, 0, ev, me, "R2");
        1: doOp(1, 0, pickAddr(ra), d, ev, me, "");
        default: doOp(0, 1, pickAddr(ra), 0, ev, me, "");
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule